// File: doc/BRIEF.md
# Configurable SRAM Read Output Stage

This block is the last stage of a synchronous SRAM's read path. Every clock edge it captures one command: a selected read, a write, or an idle/deselect cycle. It returns read data from the array model onto a data bus. The bus is modelled as a data vector `dq_out` and a separate drive enable `dq_oe`, so the high-impedance state can be compared cycle by cycle.

Two static mode inputs shape the timing.

- `pipe_mode` picks an extra output register (pipelined) or a direct path (flow-through).
- `single_desel` picks how quickly the drivers release after a deselect.

An asynchronous active-low output enable gates the drivers. A sleep request, once it has passed its entry delay, forces the bus to high-Z and blocks new commands.

Time is counted in edges. "Cycle after edge k" means the interval between edge k and edge k+1. A command is the value of `rd_cmd`/`wr_cmd` sampled at an edge. `arr_rdata` is the array's word for the read captured at the edge before it.

Top module: `sram_rd_outstage`

## Requirements
- R1: During and right after reset, `dq_oe` is 0 and `dq_out` is 0.
- R2: With `pipe_mode`=0 (flow-through), a read captured at edge k drives `dq_oe`=1 in the cycle after edge k. In that cycle `dq_out` follows `arr_rdata` combinationally.
- R3: With `pipe_mode`=1 (pipelined), a read captured at edge k is driven in the cycle after edge k+1. The value driven is the one `arr_rdata` held in the cycle after edge k. Nothing is driven in the cycle after edge k.
- R4: In pipelined mode, reads captured on consecutive edges produce one new word per cycle, in capture order, with no gap.
- R5: In pipelined mode with `single_desel`=1, `dq_oe` is 0 in any cycle whose latest captured command is not a read. This holds even when a read is still in the output register.
- R6: In pipelined mode with `single_desel`=0, a read followed by an idle cycle still drives its word. The drivers turn off only in the cycle after the second edge following the read.
- R7: In flow-through mode, a read followed by an idle command keeps the read word driven for one more cycle when `single_desel`=0. With `single_desel`=1 it turns off right after the idle edge.
- R8: In the cycle after a write is captured, `dq_oe` is 0 in every mode. This includes a write that directly follows a read.
- R9: `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge. `oe_n`=0 enables the drivers only inside a read window.
- R10: A read made while `oe_n`=1 (a dummy read) drives nothing, but it moves the pipeline forward exactly as a normal read does.
- R11: `sleep` sampled high at edge k puts the block asleep after edge k+1. While asleep, `dq_oe` is 0 and commands captured are treated as idle. Leaving sleep also takes two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | 1 = pipelined output register, 0 = flow-through (static) |
| single_desel | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect (static) |
| rd_cmd | input | 1 | Selected read command sampled at the edge |
| wr_cmd | input | 1 | Write command sampled at the edge |
| arr_rdata | input | DATA_W | Array read word for the read captured at the previous edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep request, active high |
| dq_out | output | DATA_W | Data presented to the bus |
| dq_oe | output | 1 | Bus drive enable (0 = high-Z) |

## Verification
The assertions take the mode inputs as constant between resets. They also assume `rd_cmd` and `wr_cmd` are never high in the same cycle. The stimulus follows both rules: each directed task sets the modes only while reset is held, and the command helper raises at most one of the two strobes. `oe_n` and `arr_rdata` change only between edges, so the sampled-at-edge properties see settled values.

// File: rtl/sram_oq_pkg.sv
package sram_oq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_t;

  // Read window before oe/sleep gating: latest command (newest) and one older.
  function automatic logic drive_window(input logic pipe, input logic dcd,
                                        input op_t newest, input op_t older);
    logic held;
    held = dcd && (newest == OP_IDLE);
    if (pipe) drive_window = (older == OP_READ) && ((newest == OP_READ) || held);
    else      drive_window = (newest == OP_READ) || ((older == OP_READ) && held);
  endfunction

  function automatic op_t decode_op(input logic rd, input logic wr);
    if (rd)      decode_op = OP_READ;
    else if (wr) decode_op = OP_WRITE;
    else         decode_op = OP_IDLE;
  endfunction

endpackage

// File: rtl/sram_oq_sleep_seq.sv
module sram_oq_sleep_seq #(
  parameter int ENTRY_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_in,
  output logic asleep
);
  logic [ENTRY_DLY-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= (stage_q << 1) | ENTRY_DLY'(sleep_in);
  end

  assign asleep = stage_q[ENTRY_DLY-1];

  p_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage_q[0]) && stage_q[0]) |-> ##0 (stage_q[0] == $past(sleep_in)));
endmodule

// File: rtl/sram_oq_cmd_pipe.sv
module sram_oq_cmd_pipe
  import sram_oq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_t  op_in,
  input  logic asleep,
  output op_t  op_new,
  output op_t  op_old
);
  op_t gated_op;
  assign gated_op = asleep ? OP_IDLE : op_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_new <= OP_IDLE;
      op_old <= OP_IDLE;
    end else begin
      op_new <= gated_op;
      op_old <= op_new;
    end
  end

  // R11: commands seen while asleep are captured as idle
  p_sleep_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> (op_new == OP_IDLE));
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (op_old == $past(op_new)));
endmodule

// File: rtl/sram_oq_data_stage.sv
module sram_oq_data_stage #(
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              direct,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] data_out
);
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    out_q <= '0;
    else if (load) out_q <= arr_rdata;
  end

  assign data_out = direct ? arr_rdata : out_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_q));
endmodule

// File: rtl/sram_rd_outstage.sv
module sram_rd_outstage
  import sram_oq_pkg::*;
#(
  parameter int DATA_W    = 72,
  parameter int SLEEP_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              single_desel,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic asleep;
  op_t  op_new, op_old;
  logic rd_window;
  logic direct_sel;

  sram_oq_sleep_seq #(.ENTRY_DLY(SLEEP_DLY)) u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_in(sleep), .asleep(asleep));

  sram_oq_cmd_pipe u_cmd (
    .clk(clk), .rst_n(rst_n), .op_in(decode_op(rd_cmd, wr_cmd)),
    .asleep(asleep), .op_new(op_new), .op_old(op_old));

  // Flow-through shows the array word during the captured read's own cycle.
  assign direct_sel = !pipe_mode && (op_new == OP_READ);

  sram_oq_data_stage #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(op_new == OP_READ), .direct(direct_sel),
    .arr_rdata(arr_rdata), .data_out(dq_out));

  assign rd_window = drive_window(pipe_mode, !single_desel, op_new, op_old);
  assign dq_oe     = rd_window && !oe_n && !asleep;

  p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_new == OP_WRITE) |-> !dq_oe);
  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !dq_oe);
  p_scd_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && single_desel && op_new != OP_READ) |-> !dq_oe);
  p_pipe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dq_oe) |-> $past(op_new == OP_READ));
  p_flow_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && op_new == OP_READ && !oe_n && !asleep) |-> dq_oe);
endmodule

// File: tb/sram_rd_outstage_test.sv
module sram_rd_outstage_test;
  localparam int W = 72;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pipe_mode = 1'b1, single_desel = 1'b1;
  logic         rd_cmd = 1'b0, wr_cmd = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [W-1:0] arr_rdata = '0;
  logic [W-1:0] dq_out;
  logic         dq_oe;
  int           n_checks = 0, n_fail = 0;
  bit           finished = 1'b0;

  localparam logic [W-1:0] WA = 72'hA1_0000_0000_0000_00A1;
  localparam logic [W-1:0] WB = 72'hB2_1111_2222_3333_44B2;
  localparam logic [W-1:0] WC = 72'hC3_5555_6666_7777_88C3;
  localparam logic [W-1:0] WD = 72'hD4_9999_AAAA_BBBB_CCD4;
  localparam logic [W-1:0] WX = 72'hEE_DEAD_BEEF_DEAD_BEEE;

  always #5 clk = ~clk;

  sram_rd_outstage uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .single_desel(single_desel),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .arr_rdata(arr_rdata), .oe_n(oe_n),
    .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic expect_bus(input string tag, input logic en, input logic [W-1:0] data);
    n_checks++;
    if (dq_oe !== en) begin
      n_fail++;
      $display("FAIL %s: dq_oe=%0b expected %0b at %0t", tag, dq_oe, en, $time);
    end else if (en && dq_out !== data) begin
      n_fail++;
      $display("FAIL %s: dq_out=%h expected %h at %0t", tag, dq_out, data, $time);
    end
  endtask

  // Present command, take one edge, then set the cycle's array word and oe_n.
  task automatic cyc(input logic rd, input logic wr, input logic [W-1:0] word, input logic oe);
    rd_cmd = rd; wr_cmd = wr;
    @(posedge clk);
    #1;
    rd_cmd = 1'b0; wr_cmd = 1'b0;
    arr_rdata = word; oe_n = oe;
    #1;
  endtask

  task automatic do_reset(input logic pipe, input logic scd);
    rst_n = 1'b0; pipe_mode = pipe; single_desel = scd;
    rd_cmd = 1'b0; wr_cmd = 1'b0; oe_n = 1'b0; sleep = 1'b0; arr_rdata = WX;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    do_reset(1'b1, 1'b1);
    expect_bus("R1 oe after reset", 1'b0, '0);
    n_checks++;
    if (dq_out !== '0) begin
      n_fail++;
      $display("FAIL R1 dq_out=%h expected 0", dq_out);
    end
  endtask

  task automatic t_pipe_dcd_burst;
    do_reset(1'b1, 1'b0);
    cyc(1, 0, WA, 0); expect_bus("R3 no drive first cycle", 1'b0, '0);
    cyc(1, 0, WB, 0); expect_bus("R3 word A", 1'b1, WA);
    cyc(1, 0, WC, 0); expect_bus("R4 word B", 1'b1, WB);
    cyc(1, 0, WD, 0); expect_bus("R4 word C", 1'b1, WC);
    cyc(0, 0, WX, 0); expect_bus("R6 last word D held", 1'b1, WD);
    cyc(0, 0, WX, 0); expect_bus("R6 off after second edge", 1'b0, '0);
  endtask

  task automatic t_pipe_scd;
    do_reset(1'b1, 1'b1);
    cyc(1, 0, WA, 0); expect_bus("R3 scd first", 1'b0, '0);
    cyc(1, 0, WB, 0); expect_bus("R3 scd word A", 1'b1, WA);
    cyc(0, 0, WX, 0); expect_bus("R5 cut at deselect", 1'b0, '0);
    cyc(0, 0, WX, 0); expect_bus("R5 stays off", 1'b0, '0);
  endtask

  task automatic t_flow;
    do_reset(1'b0, 1'b1);
    cyc(1, 0, WA, 0); expect_bus("R2 flow word A", 1'b1, WA);
    arr_rdata = WC; #1;
    expect_bus("R2 flow follows array", 1'b1, WC);
    cyc(0, 0, WX, 0); expect_bus("R7 flow scd off", 1'b0, '0);
    do_reset(1'b0, 1'b0);
    cyc(1, 0, WB, 0); expect_bus("R2 flow dcd word B", 1'b1, WB);
    cyc(0, 0, WX, 0); expect_bus("R7 flow dcd held B", 1'b1, WB);
    cyc(0, 0, WX, 0); expect_bus("R7 flow dcd off", 1'b0, '0);
  endtask

  task automatic t_write;
    do_reset(1'b1, 1'b0);
    cyc(1, 0, WA, 0);
    cyc(0, 1, WX, 0); expect_bus("R8 pipe dcd write after read", 1'b0, '0);
    cyc(0, 1, WX, 0); expect_bus("R8 pipe write", 1'b0, '0);
    do_reset(1'b0, 1'b0);
    cyc(1, 0, WA, 0); expect_bus("R8 flow read before write", 1'b1, WA);
    cyc(0, 1, WX, 0); expect_bus("R8 flow write", 1'b0, '0);
  endtask

  task automatic t_oe;
    do_reset(1'b1, 1'b0);
    cyc(1, 0, WA, 0);
    cyc(1, 0, WB, 1); expect_bus("R10 dummy read silent", 1'b0, '0);
    oe_n = 1'b0; #1;
    expect_bus("R9 oe low enables async", 1'b1, WA);
    oe_n = 1'b1; #1;
    expect_bus("R9 oe high disables async", 1'b0, '0);
    cyc(0, 0, WX, 0); expect_bus("R10 next read on time", 1'b1, WB);
    cyc(0, 0, WX, 0); expect_bus("R9 oe low outside window", 1'b0, '0);
  endtask

  task automatic t_sleep;
    do_reset(1'b0, 1'b1);
    sleep = 1'b1;
    cyc(1, 0, WA, 0); expect_bus("R11 still awake after one edge", 1'b1, WA);
    cyc(1, 0, WB, 0); expect_bus("R11 asleep after two edges", 1'b0, '0);
    cyc(1, 0, WC, 0); expect_bus("R11 asleep read ignored", 1'b0, '0);
    sleep = 1'b0;
    cyc(0, 0, WX, 0); expect_bus("R11 exit pending", 1'b0, '0);
    cyc(1, 0, WC, 0); expect_bus("R11 read at last sleep edge ignored", 1'b0, '0);
    cyc(1, 0, WD, 0); expect_bus("R11 awake again", 1'b1, WD);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pipe_dcd_burst();
    t_pipe_scd();
    t_flow();
    t_write();
    t_oe();
    t_sleep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule